// File: doc/BRIEF.md
# Serial-Acknowledge Interrupt Priority Chain

This block joins a row of interrupt sources into one request toward a processor. Each source owns a stage that latches its request and keeps it until it is serviced. Any stage with a pending request pulls a shared active-low request line down. The processor answers with an acknowledge pulse. That pulse enters stage 0 and passes from stage to stage. A stage lets it pass only when it has nothing pending. So the first pending stage along the row keeps the grant and places its own fixed vector on the vector output.

Each stage records whether it won the grant. When the acknowledge drops, the winner releases its request and all other requests stay latched, so the next acknowledge serves the next source in line. The set of competing requests is frozen at the moment the acknowledge rises. A request that arrives while the acknowledge is high is stored but cannot take the grant away from the stage that already holds it.

A parameter selects how requests are captured: either every clock with the request input high sets the latch, or only a rising request does.

Top module: `irq_daisy_chain`

## Requirements
- R1: While reset is asserted and after it is released, `irq_n` is 1, `vec_out` is 0, `vec_valid` is 0 and `chain_out` is 0, until a request or an acknowledge arrives.
- R2: A request bit seen high at a rising clock edge makes `irq_n` 0 from that edge onward. `irq_n` is 1 exactly when no stage has a pending request.
- R3: A request that is high for only one clock stays pending until the stage is serviced.
- R4: While `ack_in` is 1, the pending stage with the lowest index drives `vec_out` = VEC_BASE + index × VEC_STRIDE and sets `vec_valid` to 1, in the same cycle that `ack_in` rises. With the defaults, stages 0 to 3 give 0x20, 0x24, 0x28 and 0x2C.
- R5: `chain_out`, the grant leaving the last stage, is 1 only while `ack_in` is 1 and no stage was pending when the acknowledge rose.
- R6: While `ack_in` is 0, or when no stage is pending, `vec_out` is 0 and `vec_valid` is 0.
- R7: At most one stage is selected to drive the vector in any cycle.
- R8: On the clock edge after `ack_in` falls, the winning stage's request is cleared and every other pending request is kept. The next acknowledge serves the next pending stage in priority order.
- R9: A request that arrives while `ack_in` is 1 is latched and keeps `irq_n` low. It does not change `vec_out` for the rest of that acknowledge, even when its stage has a higher priority than the winner.
- R10: A request for the winning stage that is captured at the same edge that clears it leaves that stage pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NUM_STAGES | Request input of each stage; bit 0 has the highest priority |
| ack_in | input | 1 | Acknowledge from the processor, fed into stage 0 |
| irq_n | output | 1 | Shared active-low interrupt request |
| vec_out | output | VEC_W | Vector of the selected stage; 0 when no stage is selected |
| vec_valid | output | 1 | 1 while a stage drives `vec_out` |
| chain_out | output | 1 | Grant leaving the last stage |

## Verification
Two events can fall in the same cycle, and both cases are tested. The first is the clearing of a winner when the acknowledge falls, together with a fresh request for that same stage. The bench pulses the winner's request line on the falling acknowledge edge, then shows with a second acknowledge that the stage still returns its vector. The second is a high-priority request that arrives partway through an acknowledge. The bench holds the acknowledge across that request, checks that the vector does not change, and expects the newcomer to win the following acknowledge.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

   typedef enum logic {
      CAP_LEVEL = 1'b0,
      CAP_EDGE  = 1'b1
   } cap_mode_e;

   function automatic int unsigned vec_for(input int unsigned base,
                                           input int unsigned stride,
                                           input int unsigned idx);
      return base + idx * stride;
   endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter irq_chain_pkg::cap_mode_e MODE = irq_chain_pkg::CAP_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic ack_in,
   input  logic ack_fall,
   input  logic sel,
   output logic pending,
   output logic frozen
);

   logic cap;
   logic won;
   logic clr;
   logic pend_nxt;

   generate
      if (MODE == irq_chain_pkg::CAP_EDGE) begin : g_edge
         logic req_q;
         always_ff @(posedge clk) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= req;
         end
         assign cap = req & ~req_q;
      end else begin : g_level
         assign cap = req;
      end
   endgenerate

   assign clr      = ack_fall & won;
   assign pend_nxt = (pending & ~clr) | cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         frozen  <= 1'b0;
         won     <= 1'b0;
      end else begin
         pending <= pend_nxt;
         if (!ack_in) frozen <= pend_nxt;
         if (ack_fall)    won <= 1'b0;
         else if (ack_in) won <= won | sel;
      end
   end

   // R8: the winner, with no new capture, is cleared on the edge after the fall
   p_winner_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fall && won && !cap) |=> !pending);

   // R10: a capture on the clearing edge keeps the stage pending
   p_refill_survives_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fall && won && cap) |=> pending);

endmodule

// File: rtl/irq_chain_cell.sv
module irq_chain_cell #(
   parameter int unsigned VEC_W = 8,
   parameter logic [VEC_W-1:0] VEC = '0
) (
   input  logic             pi,
   input  logic             frozen,
   output logic             po,
   output logic             sel,
   output logic [VEC_W-1:0] vec_drv
);

   assign sel     = pi & frozen;
   assign po      = pi & ~frozen;
   assign vec_drv = sel ? VEC : '0;

endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge #(
   parameter int unsigned NUM   = 4,
   parameter int unsigned VEC_W = 8
) (
   input  logic [NUM-1:0][VEC_W-1:0] vec_in,
   output logic [VEC_W-1:0]          vec_out
);

   logic [NUM:0][VEC_W-1:0] acc;

   assign acc[0] = '0;
   generate
      for (genvar i = 0; i < NUM; i++) begin : g_or
         assign acc[i+1] = acc[i] | vec_in[i];
      end
   endgenerate
   assign vec_out = acc[NUM];

endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
   parameter int unsigned NUM_STAGES = 4,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VEC_BASE   = 32,
   parameter int unsigned VEC_STRIDE = 4,
   parameter irq_chain_pkg::cap_mode_e REQ_CAPTURE = irq_chain_pkg::CAP_LEVEL
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_STAGES-1:0] dev_req,
   input  logic                  ack_in,
   output logic                  irq_n,
   output logic [VEC_W-1:0]      vec_out,
   output logic                  vec_valid,
   output logic                  chain_out
);

   localparam int unsigned LAST_VEC =
      irq_chain_pkg::vec_for(VEC_BASE, VEC_STRIDE, NUM_STAGES - 1);
   localparam bit LEVEL_MODE = (REQ_CAPTURE == irq_chain_pkg::CAP_LEVEL);

   initial begin
      if (NUM_STAGES < 1)
         $error("irq_daisy_chain: NUM_STAGES must be at least 1");
      if (VEC_W < 1 || VEC_W > 31)
         $error("irq_daisy_chain: VEC_W must lie in 1..31");
      if (VEC_W <= 31 && LAST_VEC >= (32'd1 << VEC_W))
         $error("irq_daisy_chain: vectors do not fit in VEC_W bits");
      if (VEC_BASE == 0)
         $error("irq_daisy_chain: vector 0 is reserved for the idle bus");
   end

   logic                            ack_q;
   logic                            ack_fall;
   logic [NUM_STAGES:0]             grant;
   logic [NUM_STAGES-1:0]           pending;
   logic [NUM_STAGES-1:0]           frozen;
   logic [NUM_STAGES-1:0]           sel;
   logic [NUM_STAGES-1:0][VEC_W-1:0] vec_drv;

   always_ff @(posedge clk) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= ack_in;
   end
   assign ack_fall = ack_q & ~ack_in;

   assign grant[0] = ack_in;

   generate
      for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
         localparam logic [VEC_W-1:0] STAGE_VEC =
            VEC_W'(irq_chain_pkg::vec_for(VEC_BASE, VEC_STRIDE, i));

         irq_req_latch #(.MODE(REQ_CAPTURE)) u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (dev_req[i]),
            .ack_in  (ack_in),
            .ack_fall(ack_fall),
            .sel     (sel[i]),
            .pending (pending[i]),
            .frozen  (frozen[i])
         );

         irq_chain_cell #(.VEC_W(VEC_W), .VEC(STAGE_VEC)) u_cell (
            .pi     (grant[i]),
            .frozen (frozen[i]),
            .po     (grant[i+1]),
            .sel    (sel[i]),
            .vec_drv(vec_drv[i])
         );
      end
   endgenerate

   irq_vec_merge #(.NUM(NUM_STAGES), .VEC_W(VEC_W)) u_merge (
      .vec_in (vec_drv),
      .vec_out(vec_out)
   );

   assign vec_valid = |sel;
   assign chain_out = grant[NUM_STAGES];
   assign irq_n     = ~|pending;

   // R7: never more than one stage on the vector output
   p_one_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

   // R6: idle acknowledge leaves the vector output at zero
   p_idle_no_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_in |-> (vec_out == '0 && !vec_valid));

   // R9: vector holds for the whole acknowledge
   p_vec_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_in && $past(ack_in)) |-> $stable(vec_out));

   // R5: a grant leaving the chain means no stage answered
   p_pass_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chain_out |-> (ack_in && !vec_valid));

   // R2: a captured level request pulls the line low at the next cycle
   p_req_pulls_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (LEVEL_MODE && (|dev_req)) |=> !irq_n);

endmodule

// File: tb/irq_daisy_chain_bench.sv
module irq_daisy_chain_bench;

   localparam int unsigned N = 4;
   localparam int unsigned W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] dev_req = '0;
   logic         ack_in = 1'b0;
   logic         irq_n;
   logic [W-1:0] vec_out;
   logic         vec_valid;
   logic         chain_out;

   int checks = 0;
   int fails  = 0;
   int exp_q[$];

   always #2 clk = ~clk;

   irq_daisy_chain u_irq_daisy_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .dev_req  (dev_req),
      .ack_in   (ack_in),
      .irq_n    (irq_n),
      .vec_out  (vec_out),
      .vec_valid(vec_valid),
      .chain_out(chain_out)
   );

   function automatic int vec_of(input int idx);
      return 32 + idx * 4;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: compares the vector seen on each acknowledge with the queue
   initial begin
      forever begin
         @(posedge ack_in);
         #1;
         if (exp_q.size() == 0) begin
            check("R4 unexpected acknowledge", 1, 0);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (e < 0) begin
               check("R5 chain_out with nothing pending", int'(chain_out), 1);
               check("R6 vec_valid with nothing pending", int'(vec_valid), 0);
            end else begin
               check("R4 winning vector", int'(vec_out), e);
               check("R4 vec_valid", int'(vec_valid), 1);
               check("R5 chain_out blocked", int'(chain_out), 0);
            end
         end
      end
   end

   // driver: one-clock request pulse; returns just after a falling edge
   task automatic pulse_req(input logic [N-1:0] m);
      @(negedge clk);
      dev_req = m;
      @(negedge clk);
      dev_req = '0;
   endtask

   // driver: acknowledge held for one full clock, then one idle clock
   task automatic ack_cycle(input int exp);
      @(negedge clk);
      exp_q.push_back(exp);
      ack_in = 1'b1;
      @(negedge clk);
      ack_in = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #400000;
      check("watchdog expired", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R1 irq_n in reset", int'(irq_n), 1);
      check("R1 vec_out in reset", int'(vec_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R1 irq_n after reset", int'(irq_n), 1);
      check("R1 vec_valid after reset", int'(vec_valid), 0);
      check("R1 chain_out after reset", int'(chain_out), 0);

      // empty acknowledge passes straight through
      ack_cycle(-1);

      // single request on stage 2, held through an idle gap
      pulse_req(4'b0100);
      #1;
      check("R2 irq_n low after request", int'(irq_n), 0);
      repeat (3) @(negedge clk);
      #1;
      check("R3 request still pending", int'(irq_n), 0);
      check("R6 no vector without acknowledge", int'(vec_out), 0);
      ack_cycle(vec_of(2));
      #1;
      check("R8 line released after service", int'(irq_n), 1);

      // two requests: served in priority order
      pulse_req(4'b1010);
      ack_cycle(vec_of(1));
      #1;
      check("R8 lower priority kept", int'(irq_n), 0);
      ack_cycle(vec_of(3));
      #1;
      check("R8 all served", int'(irq_n), 1);
      ack_cycle(-1);

      // all four at once
      pulse_req(4'b1111);
      for (int i = 0; i < 4; i++) ack_cycle(vec_of(i));
      #1;
      check("R8 row drained", int'(irq_n), 1);

      // R9: stage 0 arrives during acknowledge of stage 2
      pulse_req(4'b0100);
      @(negedge clk);
      exp_q.push_back(vec_of(2));
      ack_in = 1'b1;
      @(negedge clk);
      dev_req = 4'b0001;
      @(negedge clk);
      dev_req = '0;
      #1;
      check("R9 vector unchanged", int'(vec_out), vec_of(2));
      check("R9 vec_valid held", int'(vec_valid), 1);
      @(negedge clk);
      ack_in = 1'b0;
      @(negedge clk);
      #1;
      check("R9 late request latched", int'(irq_n), 0);
      ack_cycle(vec_of(0));
      ack_cycle(-1);

      // R10: fresh request on the winner captured at its clearing edge
      pulse_req(4'b0010);
      @(negedge clk);
      exp_q.push_back(vec_of(1));
      ack_in = 1'b1;
      @(negedge clk);
      ack_in = 1'b0;
      dev_req = 4'b0010;
      @(negedge clk);
      dev_req = '0;
      #1;
      check("R10 refilled stage pending", int'(irq_n), 0);
      ack_cycle(vec_of(1));
      #1;
      check("R10 refilled stage served", int'(irq_n), 1);
      ack_cycle(-1);

      repeat (2) @(negedge clk);
      check("R4 scoreboard drained", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule